// File: doc/BRIEF.md
# Host-Bus Front End for a Synchronous DRAM Controller

This block sits between a processor-style host bus and the command sequencer of a synchronous DRAM controller. The host bus looks like an SRAM port. It has an active-low select, separate active-low read and write strobes, a 23-bit byte address covering 8 Mbyte (2M words of 32 bits), and a 2-bit transfer-size code. The block takes one request at a time and captures it in registers. It stalls the host through an active-low wait output until the sequencer reports completion. Burst transfers are not supported.

From the captured request the block derives the fields the sequencer needs. These are the bank, row and column, the active-low per-lane data masks, the write data steered onto the selected lanes, and an operation code. A write issued while the active-low mode-set input is low becomes a mode-register load, carrying the low 11 data bits, instead of a memory write. Read data from the sequencer is registered for the host. When lane alignment is enabled (parameter `ALIGN_NARROW`, default 1), byte and half-word read data are right-justified on the low bits of the host bus.

Top module: `sdram_host_front`

## Requirements
- R1: While reset is asserted and directly after it, `hst_wait_n` is 1, `seq_req` is 0 and `hst_rdata` is 0.
- R2: A request is accepted in a cycle where the block is idle, `hst_sel_n` is 0 and exactly one of `hst_rd_n`/`hst_wr_n` is 0. From the next cycle, `hst_wait_n` is 0 and `seq_req` is 1. Both hold, with the sequencer fields stable, until completion. Strobes with `hst_sel_n` at 1 are ignored.
- R3: The cycle after `seq_done` is sampled as 1 with `seq_req` high, `hst_wait_n` is 1 and `seq_req` is 0.
- R4: For an accepted request, `seq_bank` is address[22:21], `seq_row` is address[20:10] and `seq_col` is address[9:2].
- R5: `seq_mask_n` is active low, with bit i covering data bits [8i+7:8i]. Size code 0 (word) and code 3 give 4'b0000. Code 1 (byte) gives all ones except bit address[1:0]. Code 2 (half-word) gives 4'b0011 when address[1] is 1, and 4'b1100 otherwise.
- R6: For a memory write with alignment on, `seq_wdata` is the host data unchanged for a word. A byte write carries the low byte in all four lanes, and a half-word write carries the low half-word in both halves.
- R7: On completion of a read, with alignment on, `hst_rdata` takes the sequencer data. A word is taken unchanged. A byte is lane address[1:0] of the sequencer data, zero-extended from bits [7:0]. A half-word is bits [31:16] when address[1] is 1 and bits [15:0] otherwise, zero-extended.
- R8: `seq_op` is 2'b00 for a read and 2'b01 for a memory write. It is 2'b10 for a write made with `hst_mode_n` at 0, and in that case `seq_wdata` is the host data bits [10:0] zero-extended and `seq_mask_n` is 4'b0000. A read with `hst_mode_n` at 0 is a normal read.
- R9: A cycle with `hst_sel_n` at 0 and both strobes at 0 is ignored: no request is issued and `hst_wait_n` stays 1.
- R10: After completion, no new request is accepted until one cycle in which `hst_sel_n` is 1 or both strobes are 1.
- R11: `hst_rdata` changes only on completion of a read. Writes and mode loads leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_sel_n | input | 1 | Host select, active low |
| hst_rd_n | input | 1 | Host read strobe, active low |
| hst_wr_n | input | 1 | Host write strobe, active low |
| hst_mode_n | input | 1 | Mode-load qualifier for writes, active low |
| hst_size | input | 2 | Transfer size: 0 word, 1 byte, 2 half-word, 3 word |
| hst_addr | input | 23 | Host byte address |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Registered read data to the host |
| hst_wait_n | output | 1 | Host stall, active low |
| seq_req | output | 1 | Request to the sequencer, held until done |
| seq_op | output | 2 | Operation: 0 read, 1 write, 2 mode load |
| seq_bank | output | 2 | Bank select |
| seq_row | output | 11 | Row address |
| seq_col | output | 8 | Column address |
| seq_mask_n | output | 4 | Per-lane data masks, active low |
| seq_wdata | output | 32 | Steered write data or mode value |
| seq_done | input | 1 | Sequencer completion pulse |
| seq_rdata | input | 32 | Raw read data from the sequencer |

## Verification
The hardest state to reach is the drain after completion, where the host keeps its strobes asserted and the block must not start a second transfer. The stimulus gets there by holding select and the strobe for several cycles after wait returns high. It also holds a conflicting read-plus-write pattern in that state before releasing. The sequencer model varies its latency from one to four cycles, so completion lands at different distances from acceptance. Every byte and half-word offset is driven in both directions, so each mask and alignment case meets a distinct read pattern.

// File: rtl/sdram_hfe_pkg.sv
package sdram_hfe_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_MODE  = 2'b10
  } hfe_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_BUSY  = 2'b01,
    ST_DRAIN = 2'b10
  } hfe_state_e;

  localparam logic [1:0] SZ_WORD = 2'd0;
  localparam logic [1:0] SZ_BYTE = 2'd1;
  localparam logic [1:0] SZ_HALF = 2'd2;

endpackage

// File: rtl/hfe_ctrl.sv
module hfe_ctrl
  import sdram_hfe_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sel_n,
  input  logic rd_n,
  input  logic wr_n,
  input  logic seq_done,
  output logic take,
  output logic busy,
  output logic finish
);

  hfe_state_e st_q;
  hfe_state_e st_d;
  logic       one_strobe;
  logic       any_strobe;

  always_comb begin
    one_strobe = !sel_n && (rd_n ^ wr_n);
    any_strobe = !sel_n && !(rd_n && wr_n);
  end

  always_comb begin
    st_d   = st_q;
    take   = 1'b0;
    finish = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (one_strobe) begin
          take = 1'b1;
          st_d = ST_BUSY;
        end
      end
      ST_BUSY: begin
        if (seq_done) begin
          finish = 1'b1;
          st_d   = ST_DRAIN;
        end
      end
      ST_DRAIN: begin
        if (!any_strobe) begin
          st_d = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign busy = (st_q == ST_BUSY);

endmodule

// File: rtl/hfe_addr_split.sv
module hfe_addr_split
  import sdram_hfe_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 11,
  parameter int BANK_W = 2,
  localparam int OFF_W  = $clog2(LANES),
  localparam int ADDR_W = BANK_W + ROW_W + COL_W + OFF_W
)(
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  output logic [BANK_W-1:0] bank,
  output logic [ROW_W-1:0]  row,
  output logic [COL_W-1:0]  col,
  output logic [OFF_W-1:0]  off,
  output logic [LANES-1:0]  mask_n
);

  localparam int COL_LO  = OFF_W;
  localparam int ROW_LO  = OFF_W + COL_W;
  localparam int BANK_LO = OFF_W + COL_W + ROW_W;
  localparam int HALF_L  = LANES / 2;

  always_comb begin
    off  = addr[OFF_W-1:0];
    col  = addr[COL_LO +: COL_W];
    row  = addr[ROW_LO +: ROW_W];
    bank = addr[BANK_LO +: BANK_W];
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic byte_hit;
    logic half_hit;
    always_comb begin
      byte_hit = (off == OFF_W'(i));
      half_hit = ((i / HALF_L) != 0) == off[OFF_W-1];
      unique case (size)
        SZ_BYTE: mask_n[i] = !byte_hit;
        SZ_HALF: mask_n[i] = !half_hit;
        default: mask_n[i] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/hfe_lane_steer.sv
module hfe_lane_steer
  import sdram_hfe_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter bit ALIGN_NARROW = 1'b1,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int HW    = DATA_W / 2
)(
  input  logic [1:0]        size,
  input  logic [OFF_W-1:0]  off,
  input  logic [DATA_W-1:0] wr_in,
  output logic [DATA_W-1:0] wr_out,
  input  logic [DATA_W-1:0] rd_in,
  output logic [DATA_W-1:0] rd_out
);

  if (ALIGN_NARROW) begin : g_align
    logic [7:0]    rd_byte;
    logic [HW-1:0] rd_half;
    always_comb begin
      rd_byte = rd_in[off*8 +: 8];
      rd_half = rd_in[off[OFF_W-1]*HW +: HW];
      unique case (size)
        SZ_BYTE: begin
          wr_out = {LANES{wr_in[7:0]}};
          rd_out = {{(DATA_W-8){1'b0}}, rd_byte};
        end
        SZ_HALF: begin
          wr_out = {2{wr_in[HW-1:0]}};
          rd_out = {{HW{1'b0}}, rd_half};
        end
        default: begin
          wr_out = wr_in;
          rd_out = rd_in;
        end
      endcase
    end
  end else begin : g_pass
    logic unused_ok;
    always_comb begin
      unused_ok = ^{size, off};
      wr_out    = wr_in;
      rd_out    = rd_in;
    end
  end

endmodule

// File: rtl/sdram_host_front.sv
module sdram_host_front
  import sdram_hfe_pkg::*;
#(
  parameter int DATA_W       = 32,
  parameter int COL_W        = 8,
  parameter int ROW_W        = 11,
  parameter int BANK_W       = 2,
  parameter int MODE_W       = 11,
  parameter bit ALIGN_NARROW = 1'b1,
  localparam int LANES  = DATA_W / 8,
  localparam int OFF_W  = $clog2(LANES),
  localparam int ADDR_W = BANK_W + ROW_W + COL_W + OFF_W
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hst_sel_n,
  input  logic              hst_rd_n,
  input  logic              hst_wr_n,
  input  logic              hst_mode_n,
  input  logic [1:0]        hst_size,
  input  logic [ADDR_W-1:0] hst_addr,
  input  logic [DATA_W-1:0] hst_wdata,
  output logic [DATA_W-1:0] hst_rdata,
  output logic              hst_wait_n,
  output logic              seq_req,
  output logic [1:0]        seq_op,
  output logic [BANK_W-1:0] seq_bank,
  output logic [ROW_W-1:0]  seq_row,
  output logic [COL_W-1:0]  seq_col,
  output logic [LANES-1:0]  seq_mask_n,
  output logic [DATA_W-1:0] seq_wdata,
  input  logic              seq_done,
  input  logic [DATA_W-1:0] seq_rdata
);

  logic take;
  logic busy;
  logic finish;

  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic [DATA_W-1:0] wdata_q;
  hfe_op_e           op_q;
  hfe_op_e           op_d;
  logic [DATA_W-1:0] rdata_q;

  logic [OFF_W-1:0]  lane_off;
  logic [LANES-1:0]  split_mask_n;
  logic [DATA_W-1:0] steered_wr;
  logic [DATA_W-1:0] aligned_rd;
  logic              rdata_en;

  hfe_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_n    (hst_sel_n),
    .rd_n     (hst_rd_n),
    .wr_n     (hst_wr_n),
    .seq_done (seq_done),
    .take     (take),
    .busy     (busy),
    .finish   (finish)
  );

  always_comb begin
    if (!hst_rd_n) begin
      op_d = OP_READ;
    end else if (!hst_mode_n) begin
      op_d = OP_MODE;
    end else begin
      op_d = OP_WRITE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      size_q  <= SZ_WORD;
      wdata_q <= '0;
      op_q    <= OP_READ;
    end else if (take) begin
      addr_q  <= hst_addr;
      size_q  <= hst_size;
      wdata_q <= hst_wdata;
      op_q    <= op_d;
    end
  end

  hfe_addr_split #(
    .LANES  (LANES),
    .COL_W  (COL_W),
    .ROW_W  (ROW_W),
    .BANK_W (BANK_W)
  ) u_split (
    .addr   (addr_q),
    .size   (size_q),
    .bank   (seq_bank),
    .row    (seq_row),
    .col    (seq_col),
    .off    (lane_off),
    .mask_n (split_mask_n)
  );

  hfe_lane_steer #(
    .DATA_W       (DATA_W),
    .ALIGN_NARROW (ALIGN_NARROW)
  ) u_steer (
    .size   (size_q),
    .off    (lane_off),
    .wr_in  (wdata_q),
    .wr_out (steered_wr),
    .rd_in  (seq_rdata),
    .rd_out (aligned_rd)
  );

  assign rdata_en = finish && (op_q == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rdata_en) begin
      rdata_q <= aligned_rd;
    end
  end

  always_comb begin
    if (op_q == OP_MODE) begin
      seq_wdata  = {{(DATA_W-MODE_W){1'b0}}, wdata_q[MODE_W-1:0]};
      seq_mask_n = '0;
    end else begin
      seq_wdata  = steered_wr;
      seq_mask_n = split_mask_n;
    end
  end

  assign seq_op     = op_q;
  assign seq_req    = busy;
  assign hst_wait_n = !busy;
  assign hst_rdata  = rdata_q;

endmodule

// File: rtl/hfe_checker.sv
module hfe_checker #(
  parameter int LANES  = 4,
  parameter int COL_W  = 8,
  parameter int ROW_W  = 11,
  parameter int BANK_W = 2
)(
  input logic              clk,
  input logic              rst_n,
  input logic              hst_sel_n,
  input logic              hst_rd_n,
  input logic              hst_wr_n,
  input logic [1:0]        hst_size,
  input logic              hst_wait_n,
  input logic              seq_req,
  input logic              seq_done,
  input logic [1:0]        seq_op,
  input logic [LANES-1:0]  seq_mask_n,
  input logic [BANK_W-1:0] seq_bank,
  input logic [ROW_W-1:0]  seq_row,
  input logic [COL_W-1:0]  seq_col
);

  AST_REQ_STALLS_HOST: assert property (@(posedge clk) disable iff (!rst_n)
    seq_req |-> !hst_wait_n); // R2

  AST_ACCEPT_NEEDS_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_req) |-> $past(!hst_sel_n)); // R2

  AST_FIELDS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && $past(seq_req)) |-> $stable({seq_op, seq_mask_n, seq_bank, seq_row, seq_col})); // R2

  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && seq_done) |=> (hst_wait_n && !seq_req)); // R3

  AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && seq_op != 2'b10 && hst_size == 2'd1) |-> ($countones(~seq_mask_n) == 1)); // R5

  AST_MODE_FULL_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_req && seq_op == 2'b10) |-> (seq_mask_n == '0)); // R8

  AST_CONFLICT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (hst_wait_n && !hst_sel_n && !hst_rd_n && !hst_wr_n) |=> !seq_req); // R9

endmodule

bind sdram_host_front hfe_checker #(
  .LANES  (LANES),
  .COL_W  (COL_W),
  .ROW_W  (ROW_W),
  .BANK_W (BANK_W)
) u_hfe_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .hst_sel_n  (hst_sel_n),
  .hst_rd_n   (hst_rd_n),
  .hst_wr_n   (hst_wr_n),
  .hst_size   (hst_size),
  .hst_wait_n (hst_wait_n),
  .seq_req    (seq_req),
  .seq_done   (seq_done),
  .seq_op     (seq_op),
  .seq_mask_n (seq_mask_n),
  .seq_bank   (seq_bank),
  .seq_row    (seq_row),
  .seq_col    (seq_col)
);

// File: tb/sdram_host_front_tb_top.sv
module sdram_host_front_tb_top;

  logic        clk;
  logic        rst_n;
  logic        hst_sel_n;
  logic        hst_rd_n;
  logic        hst_wr_n;
  logic        hst_mode_n;
  logic [1:0]  hst_size;
  logic [22:0] hst_addr;
  logic [31:0] hst_wdata;
  logic [31:0] hst_rdata;
  logic        hst_wait_n;
  logic        seq_req;
  logic [1:0]  seq_op;
  logic [1:0]  seq_bank;
  logic [10:0] seq_row;
  logic [7:0]  seq_col;
  logic [3:0]  seq_mask_n;
  logic [31:0] seq_wdata;
  logic        seq_done;
  logic [31:0] seq_rdata;

  int checks;
  int errors;
  int cycles;
  bit stim_done;
  bit timeout;

  initial clk = 1'b0;
  always #5 clk = ~clk;

  sdram_host_front dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .hst_sel_n  (hst_sel_n),
    .hst_rd_n   (hst_rd_n),
    .hst_wr_n   (hst_wr_n),
    .hst_mode_n (hst_mode_n),
    .hst_size   (hst_size),
    .hst_addr   (hst_addr),
    .hst_wdata  (hst_wdata),
    .hst_rdata  (hst_rdata),
    .hst_wait_n (hst_wait_n),
    .seq_req    (seq_req),
    .seq_op     (seq_op),
    .seq_bank   (seq_bank),
    .seq_row    (seq_row),
    .seq_col    (seq_col),
    .seq_mask_n (seq_mask_n),
    .seq_wdata  (seq_wdata),
    .seq_done   (seq_done),
    .seq_rdata  (seq_rdata)
  );

  // ---------------- behavioural reference model ----------------
  int          m_state;   // 0 idle, 1 waiting on sequencer, 2 after completion
  logic [22:0] m_addr;
  logic [1:0]  m_size;
  logic [31:0] m_wdata;
  logic [1:0]  m_op;
  logic [31:0] m_rdata;

  function automatic logic [3:0] exp_mask(input logic [1:0] op, input logic [1:0] sz,
                                          input logic [22:0] a);
    logic [3:0] m;
    m = 4'b0000;
    if (op != 2'd2) begin
      if (sz == 2'd1) begin
        m = 4'b1111;
        m[a[1:0]] = 1'b0;
      end else if (sz == 2'd2) begin
        m = a[1] ? 4'b0011 : 4'b1100;
      end
    end
    return m;
  endfunction

  function automatic logic [31:0] exp_wdata(input logic [1:0] op, input logic [1:0] sz,
                                            input logic [31:0] d);
    if (op == 2'd2) return {21'd0, d[10:0]};
    if (sz == 2'd1) return {d[7:0], d[7:0], d[7:0], d[7:0]};
    if (sz == 2'd2) return {d[15:0], d[15:0]};
    return d;
  endfunction

  function automatic logic [31:0] exp_rdata(input logic [1:0] sz, input logic [22:0] a,
                                            input logic [31:0] raw);
    if (sz == 2'd1) return {24'd0, raw[8*int'(a[1:0]) +: 8]};
    if (sz == 2'd2) return a[1] ? {16'd0, raw[31:16]} : {16'd0, raw[15:0]};
    return raw;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0;
      m_addr  = '0;
      m_size  = '0;
      m_wdata = '0;
      m_op    = 2'd0;
      m_rdata = '0;
    end else begin
      case (m_state)
        0: if (!hst_sel_n && (hst_rd_n != hst_wr_n)) begin
             m_addr  = hst_addr;
             m_size  = hst_size;
             m_wdata = hst_wdata;
             m_op    = !hst_rd_n ? 2'd0 : (!hst_mode_n ? 2'd2 : 2'd1);
             m_state = 1;
           end
        1: if (seq_done) begin
             if (m_op == 2'd0) m_rdata = exp_rdata(m_size, m_addr, seq_rdata);
             m_state = 2;
           end
        default: if (hst_sel_n || (hst_rd_n && hst_wr_n)) m_state = 0;
      endcase
    end
  end

  // ---------------- sequencer model: latency 1..4 cycles ----------------
  int seq_cnt;
  int seq_txn;
  always @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seq_done  = 1'b0;
      seq_rdata = '0;
      seq_cnt   = 0;
      seq_txn   = 0;
    end else if (seq_req && !seq_done) begin
      seq_cnt++;
      if (seq_cnt >= 1 + (seq_txn % 4)) begin
        seq_done  = 1'b1;
        seq_rdata = 32'hA5C3_0000 ^ (32'h0103_0507 * (seq_txn + 1)) ^ 32'h0000_9E2B;
        seq_cnt   = 0;
        seq_txn++;
      end
    end else begin
      seq_done = 1'b0;
    end
  end

  // ---------------- checking, once per clock away from the edge ----------------
  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (timeout) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end else if (stim_done) begin
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end else if (!rst_n) begin
      chk("R1", "wait_n in reset", 32'(hst_wait_n), 32'd1);
      chk("R1", "req in reset", 32'(seq_req), 32'd0);
      chk("R1", "rdata in reset", hst_rdata, 32'd0);
    end else begin
      chk("R2/R3/R9/R10", "wait_n", 32'(hst_wait_n), 32'(m_state != 1));
      chk("R2/R3/R9/R10", "seq_req", 32'(seq_req), 32'(m_state == 1));
      chk("R7/R11", "hst_rdata", hst_rdata, m_rdata);
      if (m_state == 1) begin
        chk("R8", "seq_op", 32'(seq_op), 32'(m_op));
        chk("R4", "bank", 32'(seq_bank), 32'(m_addr[22:21]));
        chk("R4", "row", 32'(seq_row), 32'(m_addr[20:10]));
        chk("R4", "col", 32'(seq_col), 32'(m_addr[9:2]));
        chk("R5", "mask_n", 32'(seq_mask_n), 32'(exp_mask(m_op, m_size, m_addr)));
        if (m_op != 2'd0)
          chk("R6/R8", "seq_wdata", seq_wdata, exp_wdata(m_op, m_size, m_wdata));
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) timeout = 1'b1;
  end

  // ---------------- stimulus ----------------
  task automatic idle_bus();
    hst_sel_n  = 1'b1;
    hst_rd_n   = 1'b1;
    hst_wr_n   = 1'b1;
    hst_mode_n = 1'b1;
  endtask

  task automatic xfer(input bit is_rd, input bit mode, input logic [1:0] sz,
                      input logic [22:0] a, input logic [31:0] d, input int hold);
    @(negedge clk);
    hst_sel_n  = 1'b0;
    hst_rd_n   = !is_rd;
    hst_wr_n   = is_rd;
    hst_mode_n = !mode;
    hst_size   = sz;
    hst_addr   = a;
    hst_wdata  = d;
    @(negedge clk);
    while (!hst_wait_n && !timeout) @(negedge clk);
    for (int k = 0; k < hold; k++) @(negedge clk);
    idle_bus();
    @(negedge clk);
  endtask

  initial begin
    checks    = 0;
    errors    = 0;
    cycles    = 0;
    stim_done = 1'b0;
    timeout   = 1'b0;
    rst_n     = 1'b0;
    idle_bus();
    hst_size  = 2'd0;
    hst_addr  = '0;
    hst_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // word write and read, boundary addresses (R4, R6, R7)
    xfer(1'b0, 1'b0, 2'd0, 23'h12_3456, 32'hDEAD_BEEF, 0);
    xfer(1'b1, 1'b0, 2'd0, 23'h7F_FFFC, 32'h0, 0);
    xfer(1'b1, 1'b0, 2'd0, 23'h00_0000, 32'h0, 0);
    // every byte offset, both directions (R5, R6, R7)
    for (int o = 0; o < 4; o++) begin
      xfer(1'b1, 1'b0, 2'd1, 23'h2A_5550 + 23'(o), 32'h0, 0);
      xfer(1'b0, 1'b0, 2'd1, 23'h15_AAA0 + 23'(o), 32'h1122_3344 + 32'(o), 0);
    end
    // half-word offsets (R5, R6, R7)
    for (int o = 0; o < 4; o += 2) begin
      xfer(1'b1, 1'b0, 2'd2, 23'h40_0800 + 23'(o), 32'h0, 0);
      xfer(1'b0, 1'b0, 2'd2, 23'h3F_F7F0 + 23'(o), 32'h5566_7788, 0);
    end
    // size code 3 acts as word (R5)
    xfer(1'b1, 1'b0, 2'd3, 23'h01_0203, 32'h0, 0);
    xfer(1'b0, 1'b0, 2'd3, 23'h01_0207, 32'h99AA_BBCC, 0);
    // mode load and a read with mode qualifier low (R8, R11)
    xfer(1'b0, 1'b1, 2'd1, 23'h55_5555, 32'hFFFF_F237, 0);
    xfer(1'b1, 1'b1, 2'd0, 23'h33_3333, 32'h0, 0);
    // conflicting strobes are ignored (R9)
    @(negedge clk);
    hst_sel_n = 1'b0;
    hst_rd_n  = 1'b0;
    hst_wr_n  = 1'b0;
    repeat (4) @(negedge clk);
    idle_bus();
    // strobe without select is ignored (R2)
    hst_rd_n = 1'b0;
    repeat (3) @(negedge clk);
    idle_bus();
    @(negedge clk);
    // strobes held after completion: no second transfer (R10)
    xfer(1'b1, 1'b0, 2'd1, 23'h0A_BC02, 32'h0, 4);
    xfer(1'b0, 1'b0, 2'd2, 23'h0A_BC06, 32'hCAFE_F00D, 3);
    // conflict pattern held in drain, then release (R9, R10)
    @(negedge clk);
    hst_sel_n = 1'b0;
    hst_rd_n  = 1'b0;
    hst_addr  = 23'h66_0001;
    hst_size  = 2'd1;
    @(negedge clk);
    while (!hst_wait_n && !timeout) @(negedge clk);
    hst_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    idle_bus();
    repeat (3) @(negedge clk);
    stim_done = 1'b1;
  end

endmodule